// File: doc/BRIEF.md
# Error Event Interrupt Collector with Stop Handshake

This block sits beside a group of error-detection checkers and turns their one-cycle error pulses into sticky per-source pending flags. Each of its eight sources has its own interrupt enable; the block drives one registered interrupt line that is high whenever some source is both pending and enabled. Software reaches the flags through a small register port with valid/ready requests and a registered read response. It can set or clear enables, clear pending flags by writing ones, and read a revision word and a status word.

The block also takes part in clock-stop and reset sequencing. It reports idle only when no flag at all is pending, and that includes sources whose interrupt is disabled. A stop request is acknowledged only from the idle state. A pending flag that software never clears therefore holds the request off for as long as it stays set. A checker that keeps firing can only be let through by masking it at its own input and then clearing its flag. Once given, the acknowledge stays high until the request is withdrawn. Events that arrive during that time are still recorded.

Top module: `err_aggr`

## Requirements
- R1: A pulse on `evtPulse[i]` sets pending flag i at that clock edge, whether or not source i is enabled. Pending flags read at word offset 0x8, bit i = source i.
- R2: A pending flag stays set until software clears it. Writing 0 to a bit at 0x8 leaves that flag unchanged.
- R3: Writing 1 to bit i at 0x8 clears flag i. If an event on source i arrives in the same cycle, the flag stays set.
- R4: A write to 0x4 sets the enables given in data bits [7:0] and clears the enables given in bits [15:8]. If one bit is in both, clear wins. Reading 0x4 returns the enables in bits [7:0]. All enables are 0 after reset.
- R5: `irq` is high one cycle after a cycle in which some flag is both pending and enabled, and low otherwise. A pending flag whose source is disabled never raises `irq`.
- R6: `idle` is high exactly when no pending flag is set. Reading 0x8's sibling status word at 0xC returns pending-and-enabled in bits [7:0], idle in bit 16 and the stop acknowledge in bit 17.
- R7: `stopAck` rises in the cycle after an edge where `stopReq` is high and the block is idle. It never rises while any flag is pending.
- R8: `stopAck` stays high while `stopReq` stays high, even if new events arrive and clear `idle`. It falls one cycle after `stopReq` falls.
- R9: Offset 0x0 is a read-only revision word: major number in bits [23:16], minor in [15:8], RTL revision in [7:0] (defaults 2, 1, 1). Writes to it change nothing.
- R10: `reqReady` is always high. A read accepted at one edge gives `rspValid` high and the read data on `rspRdata` for the following cycle. Otherwise `rspRdata` is 0.
- R11: After reset, all flags and enables are clear, `irq` and `stopAck` are low and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 8 | One-cycle error pulses, one per source |
| reqValid | input | 1 | Register request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 4 | Byte offset; bits [3:2] select the word |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Request accepted (always high) |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Read data |
| stopReq | input | 1 | Clock-stop / reset request |
| stopAck | output | 1 | Stop acknowledge |
| irq | output | 1 | Combined interrupt |
| idle | output | 1 | No pending flag set |

## Verification
The bench holds a stop request while a disabled source is pending. A design that computed idle from enabled sources only would acknowledge at once. It also clears a flag in the same cycle a new event arrives on that source, and a design that let the clear win would lose the event. Events arriving during an acknowledged stop must keep the acknowledge high while dropping idle. A design that re-qualified the acknowledge every cycle would drop it mid-handshake. A long random phase of mixed events, enable changes, clears and stop requests is compared against a behavioural model every cycle.

// File: rtl/err_aggr_pkg.sv
package err_aggr_pkg;
  parameter int unsigned SRC_N = 8;

  typedef struct packed {
    logic [SRC_N-1:0] enSet;
    logic [SRC_N-1:0] enClr;
    logic [SRC_N-1:0] pendClr;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    W_REV  = 2'd0,
    W_EN   = 2'd1,
    W_PEND = 2'd2,
    W_STAT = 2'd3
  } wordSel_e;
endpackage

// File: rtl/err_aggr_dp.sv
module err_aggr_dp import err_aggr_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] evtPulse,
  input  ctrlStrobes_t     strb,
  output logic [SRC_N-1:0] pendVec,
  output logic [SRC_N-1:0] enVec,
  output logic             irq,
  output logic             idle
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic pendBit;
    logic enBit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendBit <= 1'b0;
        enBit   <= 1'b0;
      end else begin
        pendBit <= evtPulse[i] | (pendBit & ~strb.pendClr[i]);
        enBit   <= ~strb.enClr[i] & (enBit | strb.enSet[i]);
      end
    end

    assign pendVec[i] = pendBit;
    assign enVec[i]   = enBit;

    p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> pendVec[i]);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
      (pendVec[i] && !strb.pendClr[i]) |=> pendVec[i]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.pendClr[i] && !evtPulse[i]) |=> !pendVec[i]);
    p_en_clear_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
      strb.enClr[i] |=> !enVec[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(pendVec & enVec);
  end

  assign idle = ~|pendVec;

  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & enVec) == '0) |=> !irq);
endmodule

// File: rtl/err_aggr_ctrl.sv
module err_aggr_ctrl import err_aggr_pkg::*; #(
  parameter int unsigned AW      = 4,
  parameter int unsigned DW      = 32,
  parameter logic [7:0]  REV_MAJ = 8'd2,
  parameter logic [7:0]  REV_MIN = 8'd1,
  parameter logic [7:0]  REV_RTL = 8'd1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqAddr,
  input  logic [DW-1:0]    reqWdata,
  output logic             reqReady,
  output logic             rspValid,
  output logic [DW-1:0]    rspRdata,
  input  logic             stopReq,
  output logic             stopAck,
  input  logic [SRC_N-1:0] pendVec,
  input  logic [SRC_N-1:0] enVec,
  input  logic             idle,
  output ctrlStrobes_t     strb
);
  localparam int unsigned IDLE_BIT = 16;
  localparam int unsigned ACK_BIT  = 17;

  wordSel_e   word;
  logic       wrEn;
  logic       rdEn;
  logic [DW-1:0] rdMux;
  logic       unusedBits;

  assign word       = wordSel_e'(reqAddr[3:2]);
  assign wrEn       = reqValid & reqWrite;
  assign rdEn       = reqValid & ~reqWrite;
  assign reqReady   = 1'b1;
  assign unusedBits = ^{reqWdata[DW-1:2*SRC_N], reqAddr[1:0]};

  always_comb begin
    strb = '0;
    if (wrEn && word == W_EN) begin
      strb.enSet = reqWdata[SRC_N-1:0];
      strb.enClr = reqWdata[2*SRC_N-1:SRC_N];
    end
    if (wrEn && word == W_PEND) strb.pendClr = reqWdata[SRC_N-1:0];
  end

  always_comb begin
    rdMux = '0;
    unique case (word)
      W_REV: begin
        rdMux[23:16] = REV_MAJ;
        rdMux[15:8]  = REV_MIN;
        rdMux[7:0]   = REV_RTL;
      end
      W_EN:   rdMux[SRC_N-1:0] = enVec;
      W_PEND: rdMux[SRC_N-1:0] = pendVec;
      W_STAT: begin
        rdMux[SRC_N-1:0] = pendVec & enVec;
        rdMux[IDLE_BIT]  = idle;
        rdMux[ACK_BIT]   = stopAck;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
      stopAck  <= 1'b0;
    end else begin
      rspValid <= rdEn;
      rspRdata <= rdEn ? rdMux : '0;
      stopAck  <= stopReq & (stopAck | idle);
    end
  end

  p_ack_needs_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopAck) |-> $past(idle));
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopAck && stopReq) |=> stopAck);
  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stopReq |=> !stopAck);
  p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rspValid);
endmodule

// File: rtl/err_aggr.sv
module err_aggr import err_aggr_pkg::*; #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [7:0]  REV_MAJ = 8'd2,
  parameter logic [7:0]  REV_MIN = 8'd1,
  parameter logic [7:0]  REV_RTL = 8'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  evtPulse,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  input  logic              stopReq,
  output logic              stopAck,
  output logic              irq,
  output logic              idle
);
  ctrlStrobes_t     strb;
  logic [SRC_N-1:0] pendVec;
  logic [SRC_N-1:0] enVec;

  err_aggr_ctrl #(
    .AW(ADDR_W), .DW(DATA_W),
    .REV_MAJ(REV_MAJ), .REV_MIN(REV_MIN), .REV_RTL(REV_RTL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspRdata(rspRdata),
    .stopReq(stopReq), .stopAck(stopAck),
    .pendVec(pendVec), .enVec(enVec), .idle(idle), .strb(strb)
  );

  err_aggr_dp u_dp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .strb(strb),
    .pendVec(pendVec), .enVec(enVec), .irq(irq), .idle(idle)
  );
endmodule

// File: tb/err_aggr_bench.sv
module err_aggr_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [7:0]  evtPulse;
  logic        reqValid, reqWrite;
  logic [3:0]  reqAddr;
  logic [31:0] reqWdata;
  logic        reqReady, rspValid;
  logic [31:0] rspRdata;
  logic        stopReq, stopAck, irq, idle;

  err_aggr u_err_aggr (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspRdata(rspRdata),
    .stopReq(stopReq), .stopAck(stopAck), .irq(irq), .idle(idle)
  );

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  logic [7:0]  mPend, mEn;
  logic        mIrq, mAck, mRspV;
  logic [31:0] mRspD;
  logic [3:0]  mLastAddr;

  function automatic logic [31:0] refRead(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return 32'h0002_0101;
      2'd1:    return {24'b0, mEn};
      2'd2:    return {24'b0, mPend};
      default: return {14'b0, mAck, (mPend == 8'h00), 8'b0, mPend & mEn};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelStep();
    logic        rd;
    logic [31:0] rv;
    logic [7:0]  clr, es, ec;
    rd  = reqValid && !reqWrite;
    rv  = refRead(reqAddr);
    clr = (reqValid && reqWrite && reqAddr[3:2] == 2'd2) ? reqWdata[7:0] : 8'h00;
    es  = (reqValid && reqWrite && reqAddr[3:2] == 2'd1) ? reqWdata[7:0] : 8'h00;
    ec  = (reqValid && reqWrite && reqAddr[3:2] == 2'd1) ? reqWdata[15:8] : 8'h00;
    mIrq  = |(mPend & mEn);
    mAck  = stopReq && (mAck || mPend == 8'h00);
    mPend = (mPend & ~clr) | evtPulse;
    mEn   = (mEn | es) & ~ec;
    mRspV = rd;
    mRspD = rd ? rv : 32'h0;
    if (rd) mLastAddr = reqAddr;
  endtask

  task automatic cyc();
    string rtag;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    case (mLastAddr[3:2])
      2'd0:    rtag = "R9 revision read";
      2'd1:    rtag = "R4 enable read";
      2'd2:    rtag = "R1/R2/R3 pending read";
      default: rtag = "R6 status read";
    endcase
    chk("R10 reqReady", {31'b0, reqReady}, 32'd1);
    chk("R5 irq", {31'b0, irq}, {31'b0, mIrq});
    chk("R6 idle", {31'b0, idle}, {31'b0, (mPend == 8'h00)});
    chk("R7/R8 stopAck", {31'b0, stopAck}, {31'b0, mAck});
    chk("R10 rspValid", {31'b0, rspValid}, {31'b0, mRspV});
    chk(rtag, rspRdata, mRspD);
  endtask

  task automatic busIdle();
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = 4'h0; reqWdata = 32'h0;
  endtask

  task automatic busW(input logic [3:0] a, input logic [31:0] d);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    cyc();
    busIdle();
  endtask

  task automatic busR(input logic [3:0] a);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqWdata = 32'h0;
    cyc();
    busIdle();
  endtask

  task automatic pulse(input logic [7:0] m);
    evtPulse = m;
    cyc();
    evtPulse = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; evtPulse = 8'h00; stopReq = 1'b0;
    busIdle();
    mPend = 0; mEn = 0; mIrq = 0; mAck = 0; mRspV = 0; mRspD = 0; mLastAddr = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 idle after reset", {31'b0, idle}, 32'd1);
    chk("R11 irq after reset", {31'b0, irq}, 32'd0);
    chk("R11 stopAck after reset", {31'b0, stopAck}, 32'd0);
    chk("R11 rspValid after reset", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;
    cyc();
    busR(4'h4);
    chk("R11 enables clear", rspRdata, 32'h0);

    // R9: revision word, read-only
    busR(4'h0);
    chk("R9 revision", rspRdata, 32'h0002_0101);
    busW(4'h0, 32'hFFFF_FFFF);
    busR(4'h0);
    chk("R9 revision after write", rspRdata, 32'h0002_0101);

    // R1/R5: disabled source still latches, no irq
    pulse(8'h04);
    cyc();
    chk("R5 disabled source no irq", {31'b0, irq}, 32'd0);
    busR(4'h8);
    chk("R1 pending with enable off", rspRdata, 32'h04);
    busW(4'h8, 32'h0);
    busR(4'h8);
    chk("R2 zero write keeps pending", rspRdata, 32'h04);

    // R7: stop stalls while a disabled source is pending
    stopReq = 1'b1;
    repeat (4) cyc();
    chk("R7 no ack while pending", {31'b0, stopAck}, 32'd0);

    // R4/R5: enable raises irq
    busW(4'h4, 32'h0000_0004);
    cyc();
    chk("R5 irq after enable", {31'b0, irq}, 32'd1);
    busR(4'hC);
    chk("R6 status word", rspRdata, 32'h0000_0004);

    // R3: clear; then ack
    busW(4'h8, 32'h0000_0004);
    chk("R3 cleared -> idle", {31'b0, idle}, 32'd1);
    cyc();
    chk("R7 ack after idle", {31'b0, stopAck}, 32'd1);
    busR(4'hC);
    chk("R6 status idle+ack", rspRdata, 32'h0003_0000);

    // R8: event during ack
    pulse(8'h80);
    chk("R8 idle drops during ack", {31'b0, idle}, 32'd0);
    chk("R8 ack held", {31'b0, stopAck}, 32'd1);
    stopReq = 1'b0;
    cyc();
    chk("R8 ack falls after release", {31'b0, stopAck}, 32'd0);
    busW(4'h8, 32'h80);

    // R3: event and clear in same cycle on one source
    pulse(8'h10);
    evtPulse = 8'h10;
    busW(4'h8, 32'h10);
    evtPulse = 8'h00;
    busR(4'h8);
    chk("R3 event wins over clear", rspRdata, 32'h10);
    busW(4'h8, 32'h10);

    // R4: set and clear same bit, clear wins
    busW(4'h4, 32'h0000_0404);
    busR(4'h4);
    chk("R4 clear wins", rspRdata, 32'h0);
    busW(4'h4, 32'h0000_00F3);
    busR(4'h4);
    chk("R4 enable set", rspRdata, 32'hF3);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      evtPulse = (($urandom % 6) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
      if (($urandom % 25) == 0) stopReq = ~stopReq;
      case ($urandom % 5)
        0: begin reqValid = 1; reqWrite = 0; reqAddr = 4'(($urandom % 4) << 2); reqWdata = 0; end
        1: begin reqValid = 1; reqWrite = 1; reqAddr = 4'h8; reqWdata = $urandom; end
        2: begin reqValid = 1; reqWrite = 1; reqAddr = 4'(($urandom % 4) << 2); reqWdata = $urandom; end
        default: busIdle();
      endcase
      cyc();
    end
    busIdle();
    evtPulse = 8'h00;
    cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule